// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines and turns them into a single request to the processor, together with the address of the handler entry that should run. Software sees a word-addressed register file. It can program a per-source configuration word, mask sources through an enable register, and raise interrupts itself through a software-interrupt register. Both the enable register and the software-interrupt register have bit-set and bit-clear aliases, so one source can be changed without a read-modify-write.

A source is pending when it is enabled and either its hardware line is high or its software bit is set. Among the pending sources, the one with the lowest index wins. The winner's index is turned into a vector address as follows: a table base plus the index times an entry size. The entry size is four bytes shifted left by a small field in the controller configuration. The pending mask, the selection, the status word, the vector address and the processor request are all recomputed every cycle from the registered state. They therefore follow input-line changes and register writes with a fixed latency of one cycle.

The per-source configuration words are storage only and play no part in selection. Accesses are always full 32-bit words: a write strobe with a word address and write data, and read data that reflects the addressed register combinationally.

Top module: `vic_core`

## Requirements
- R1: After reset every register reads zero and `cpu_irq_o` is low.
- R2: Word addresses 0 to 31 are per-source configuration registers; a write keeps only bits 12:0 and the upper bits read zero.
- R3: Address 32 is the enable register and is written directly. A write to address 33 ORs the data into enable. A write to address 34 clears the enable bits that are set in the data.
- R4: Address 37 is the software-interrupt register and is written directly. Address 38 ORs the data into it, and address 39 clears the bits that are set in the data.
- R5: Address 36 (raw status) shows bit i equal to input line i as sampled on the previous clock edge.
- R6: Address 35 (pending) reads (raw status OR software interrupt) AND enable.
- R7: When several sources are pending, the lowest-numbered one is selected.
- R8: Address 40 (controller config) keeps only bits 3:0. Address 42 is the vector table base. Address 43 reads base + index × (4 << config[2:0]) for the selected source.
- R9: With a source selected, address 41 (status) reads bit 31 set and the index in bits 4:0, and `cpu_irq_o` is high. With nothing pending, status and vector address read zero and `cpu_irq_o` is low.
- R10: Writes to addresses 35, 36, 41 and 43 have no effect.
- R11: The pending mask, status, vector address and `cpu_irq_o` change one clock edge after the registered state they depend on changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | 32 | Level-sensitive request lines, one per source |
| bus_we_i | input | 1 | Write strobe for the addressed register |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register |
| cpu_irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the request lines and the bus inputs are stable around each rising edge. They also assume that reset is held for at least one edge, so that the previous-cycle terms they compare against come from a defined state. The bench meets these conditions by changing every input only on the falling clock edge and by holding reset for several cycles before any access. No two bus operations overlap, because each write strobe lasts exactly one cycle and the address is then handed back to reads.

// File: rtl/vic_core.sv
module vic_core #(
  parameter int NSRC   = 32,
  parameter int DW     = 32,
  parameter int ADDR_W = 6,
  parameter int CFG_W  = 13,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_lines_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              cpu_irq_o
);
  localparam int IW = $clog2(NSRC);
  localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(NSRC + 0);
  localparam logic [ADDR_W-1:0] A_ENSET  = ADDR_W'(NSRC + 1);
  localparam logic [ADDR_W-1:0] A_ENCLR  = ADDR_W'(NSRC + 2);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(NSRC + 3);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(NSRC + 4);
  localparam logic [ADDR_W-1:0] A_SW     = ADDR_W'(NSRC + 5);
  localparam logic [ADDR_W-1:0] A_SWSET  = ADDR_W'(NSRC + 6);
  localparam logic [ADDR_W-1:0] A_SWCLR  = ADDR_W'(NSRC + 7);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(NSRC + 8);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(NSRC + 9);
  localparam logic [ADDR_W-1:0] A_BASE   = ADDR_W'(NSRC + 10);
  localparam logic [ADDR_W-1:0] A_VEC    = ADDR_W'(NSRC + 11);

  logic [CFG_W-1:0]  cfg_q [NSRC];
  logic [NSRC-1:0]   en_q, sw_q, raw_q, pend_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     base_q, stat_q, vec_q;
  logic              irq_q;

  logic [NSRC-1:0] pend_d;
  logic            hit_d;
  logic [IW-1:0]   idx_d;
  logic [NSRC-1:0] wmask;

  assign wmask  = bus_wdata_i[NSRC-1:0];
  assign pend_d = (raw_q | sw_q) & en_q;

  always_comb begin
    hit_d = 1'b0;
    idx_d = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_d[i]) begin
        hit_d = 1'b1;
        idx_d = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) cfg_q[i] <= '0;
      en_q   <= '0;
      sw_q   <= '0;
      ctrl_q <= '0;
      base_q <= '0;
    end else if (bus_we_i) begin
      for (int i = 0; i < NSRC; i++)
        if (bus_addr_i == ADDR_W'(i)) cfg_q[i] <= bus_wdata_i[CFG_W-1:0];
      case (bus_addr_i)
        A_EN:    en_q   <= wmask;
        A_ENSET: en_q   <= en_q | wmask;
        A_ENCLR: en_q   <= en_q & ~wmask;
        A_SW:    sw_q   <= wmask;
        A_SWSET: sw_q   <= sw_q | wmask;
        A_SWCLR: sw_q   <= sw_q & ~wmask;
        A_CTRL:  ctrl_q <= bus_wdata_i[CTRL_W-1:0];
        A_BASE:  base_q <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      pend_q <= '0;
      stat_q <= '0;
      vec_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= irq_lines_i;
      pend_q <= pend_d;
      irq_q  <= hit_d;
      stat_q <= hit_d ? {1'b1, {(DW-1-IW){1'b0}}, idx_d} : '0;
      vec_q  <= hit_d ? base_q + (DW'(idx_d) << (2 + ctrl_q[2:0])) : '0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_EN:    bus_rdata_o = DW'(en_q);
      A_PEND:  bus_rdata_o = DW'(pend_q);
      A_RAW:   bus_rdata_o = DW'(raw_q);
      A_SW:    bus_rdata_o = DW'(sw_q);
      A_CTRL:  bus_rdata_o = DW'(ctrl_q);
      A_STAT:  bus_rdata_o = stat_q;
      A_BASE:  bus_rdata_o = base_q;
      A_VEC:   bus_rdata_o = vec_q;
      default:
        if (bus_addr_i < ADDR_W'(NSRC)) bus_rdata_o = DW'(cfg_q[bus_addr_i[IW-1:0]]);
    endcase
  end

  assign cpu_irq_o = irq_q;

  p_raw_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> raw_q == $past(irq_lines_i));

  p_pend_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pend_q & ~$past(en_q)) == '0);

  p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (pend_q[stat_q[IW-1:0]] &&
               ((pend_q & ((NSRC'(1) << stat_q[IW-1:0]) - NSRC'(1))) == '0)));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q |-> (stat_q == '0 && vec_q == '0 && pend_q == '0));

  p_irq_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == stat_q[DW-1]);

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> irq_q == ($past((raw_q | sw_q) & en_q) != '0));
endmodule

// File: tb/vic_core_tb.sv
module vic_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines = '0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  vic_core dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(lines), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cpu_irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 check(req, rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1", 6'd32, 0);
    rd_chk("R1", 6'd41, 0);
    rd_chk("R1", 6'd43, 0);
    rd_chk("R1", 6'd3, 0);
    check("R1", {31'b0, irq}, 0);
  endtask

  task automatic t_cfg;
    wr(6'd5, 32'hFFFF_FFFF);
    rd_chk("R2", 6'd5, 32'h0000_1FFF);
    rd_chk("R2", 6'd6, 0);
    wr(6'd40, 32'h0000_00FF);
    rd_chk("R8", 6'd40, 32'h0000_000F);
    wr(6'd40, 0);
  endtask

  task automatic t_enable;
    wr(6'd33, 32'h0000_00F0);
    rd_chk("R3", 6'd32, 32'h0000_00F0);
    wr(6'd33, 32'h0000_0003);
    rd_chk("R3", 6'd32, 32'h0000_00F3);
    wr(6'd34, 32'h0000_0030);
    rd_chk("R3", 6'd32, 32'h0000_00C3);
  endtask

  task automatic t_soft_vector;
    wr(6'd38, 32'h0000_0100);
    rd_chk("R4", 6'd37, 32'h0000_0100);
    rd_chk("R6", 6'd35, 0);
    check("R6", {31'b0, irq}, 0);
    wr(6'd33, 32'h0000_0100);
    rd_chk("R6", 6'd35, 32'h0000_0100);
    rd_chk("R9", 6'd41, 32'h8000_0008);
    check("R9", {31'b0, irq}, 1);
    wr(6'd42, 32'h0000_1000);
    rd_chk("R8", 6'd43, 32'h0000_1020);
    wr(6'd40, 32'h0000_0003);
    rd_chk("R8", 6'd43, 32'h0000_1100);
    wr(6'd40, 32'h0000_000F);
    rd_chk("R8", 6'd43, 32'h0000_2000);
    wr(6'd40, 0);
  endtask

  task automatic t_lines_priority;
    wr(6'd32, 32'hFFFF_FFFF);
    @(negedge clk) lines = 32'hA500_0000;
    @(negedge clk);
    rd_chk("R5", 6'd36, 32'hA500_0000);
    rd_chk("R6", 6'd35, 32'hA500_0100);
    rd_chk("R7", 6'd41, 32'h8000_0008);
    wr(6'd39, 32'h0000_0100);
    rd_chk("R4", 6'd37, 0);
    rd_chk("R7", 6'd41, 32'h8000_0018);
    @(negedge clk) lines = 32'hA500_0001;
    @(negedge clk);
    rd_chk("R7", 6'd41, 32'h8000_0000);
    rd_chk("R8", 6'd43, 32'h0000_1000);
    @(negedge clk) lines = 32'h8000_0000;
    @(negedge clk);
    rd_chk("R7", 6'd41, 32'h8000_001F);
    wr(6'd37, 32'h0000_0040);
    rd_chk("R4", 6'd37, 32'h0000_0040);
    rd_chk("R7", 6'd41, 32'h8000_0006);
    wr(6'd37, 0);
  endtask

  task automatic t_readonly;
    wr(6'd35, 32'hDEAD_BEEF);
    wr(6'd36, 32'hDEAD_BEEF);
    wr(6'd41, 32'hDEAD_BEEF);
    wr(6'd43, 32'hDEAD_BEEF);
    rd_chk("R10", 6'd35, 32'h8000_0000);
    rd_chk("R10", 6'd36, 32'h8000_0000);
    rd_chk("R10", 6'd41, 32'h8000_001F);
    rd_chk("R10", 6'd43, 32'h0000_1000 + 32'd31 * 4);
    rd_chk("R10", 6'd32, 32'hFFFF_FFFF);
  endtask

  task automatic t_latency_idle;
    @(negedge clk) lines = 0;
    @(negedge clk);
    check("R11", {31'b0, irq}, 1);
    @(negedge clk);
    check("R11", {31'b0, irq}, 0);
    rd_chk("R9", 6'd41, 0);
    rd_chk("R9", 6'd43, 0);
    lines = 32'h0000_0020;
    @(negedge clk);
    check("R11", {31'b0, irq}, 0);
    @(negedge clk);
    check("R11", {31'b0, irq}, 1);
    @(negedge clk);
    we = 1'b1; addr = 6'd34; wdata = 32'h0000_0020;
    @(negedge clk);
    we = 1'b0;
    check("R11", {31'b0, irq}, 1);
    @(negedge clk);
    check("R11", {31'b0, irq}, 0);
    lines = 0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg();
    t_enable();
    t_soft_vector();
    t_lines_priority();
    t_readonly();
    t_latency_idle();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule